// File: doc/BRIEF.md
# Camera Stream Frame and Line Marker

This block sits between the receive stream of a camera serial link and the write port of a DMA FIFO. Frame boundaries are signalled per virtual channel by a level on a frame-sync line. The block tracks the last recorded level of each of these lines. When a line changes level, it writes one in-band marker word into the FIFO. The word is flagged by a marker bit and carries a start-of-frame or end-of-frame code together with the channel index. The incoming stream is held off for the single cycle in which the marker is written.

Line framing does not depend on any line-sync signal. The first beat of every long packet is tagged as line start. The byte length from the packet header is then counted down beat by beat, and the beat that uses up the count is tagged as line end with its valid byte count. A whole frame sent as one packet is handled in the same way.

Top module: `csi_frame_tagger`

## Requirements
- R1: While reset is asserted, with all frame-sync lines low and no input beat offered, m_valid is 0 and s_ready equals m_ready.
- R2: A rising level on vsync_i[v] that differs from the recorded level produces a marker word: m_meta=1, m_vc=v, m_data[1:0]=2'b01 (frame start), the other m_data bits 0, m_bytes=0, m_sol=0, m_eol=0.
- R3: A falling level on vsync_i[v] produces the same marker form with m_data[1:0]=2'b10 (frame end).
- R4: In every cycle in which a marker is offered, s_ready is 0. Once the marker is accepted, the channel's recorded level is updated and that edge produces no further marker.
- R5: When a sync edge and an input beat are present in the same cycle, the marker is written first. The beat is held by s_ready=0 and passes on a later cycle.
- R6: When m_ready is 0, s_ready is 0 and a pending marker stays offered until it is accepted.
- R7: A data beat with s_pkt_start=1 is written with m_sol=1. Every other data beat has m_sol=0.
- R8: The byte length is taken from s_pkt_len on the start beat. Each accepted data beat carries m_bytes = min(remaining, 4) and lowers the remaining count by that amount. m_eol=1 on the beat where the remaining count is nonzero and at most 4.
- R9: A packet holding a whole frame (length well above one line, for example 40 bytes) follows the same counting: one line start, full beats, and one line end.
- R10: If edges are pending on several channels at once, the lowest channel index is written first, one marker per cycle.
- R11: A data word has m_meta=0, m_vc=s_vc and m_data=s_data, and it is offered in the same cycle as s_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_i | input | 4 | Frame-sync level per virtual channel |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted |
| s_data | input | 32 | Input beat payload |
| s_vc | input | 2 | Virtual channel of the input beat |
| s_pkt_start | input | 1 | Beat is the first of a long packet |
| s_pkt_len | input | 16 | Packet byte length, used on the start beat |
| m_valid | output | 1 | FIFO write valid |
| m_ready | input | 1 | FIFO has room |
| m_data | output | 32 | Payload, or marker code in bits 1:0 |
| m_bytes | output | 3 | Valid bytes in the word |
| m_sol | output | 1 | Line start |
| m_eol | output | 1 | Line end |
| m_meta | output | 1 | Word is a frame marker |
| m_vc | output | 2 | Virtual channel index |

## Verification
All FIFO-side outputs and s_ready are combinational in the current inputs and state, so each result is due in the same cycle as its stimulus. Recorded sync levels and the remaining byte count change at the clock edge that accepts a word, so their effect first shows one cycle later. The bench applies inputs at the falling edge and samples 1 ns later. It advances its reference model only at the rising edge, using the handshake it predicted, and so it compares the outputs of every cycle at the point where they are due.

// File: rtl/csi_tag_pkg.sv
package csi_tag_pkg;
  typedef enum logic [1:0] {
    MARK_NONE = 2'b00,
    MARK_SOF  = 2'b01,
    MARK_EOF  = 2'b10
  } mark_code_t;
endpackage

// File: rtl/csi_vs_track.sv
module csi_vs_track #(
  parameter int NUM_VC = 4,
  parameter int VC_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_VC-1:0] vsync_i,
  input  logic              take_i,
  output logic              req_o,
  output logic [VC_W-1:0]   sel_o,
  output logic              rise_o
);
  logic [NUM_VC-1:0] lvl_q, lvl_d, diff;

  assign diff  = vsync_i ^ lvl_q;
  assign req_o = |diff;

  // lowest channel with a pending edge wins
  always_comb begin
    sel_o = '0;
    for (int i = NUM_VC - 1; i >= 0; i--) begin
      if (diff[i]) sel_o = VC_W'(i);
    end
  end

  assign rise_o = vsync_i[sel_o];

  always_comb begin
    lvl_d = lvl_q;
    if (take_i) lvl_d[sel_o] = vsync_i[sel_o];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end

  // R4: one accepted marker retires exactly one channel's edge
  assert_one_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> ($countones(lvl_q ^ $past(lvl_q)) == 1));
  // R6: without acceptance the recorded levels stay put
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |=> $stable(lvl_q));
endmodule

// File: rtl/csi_line_count.sv
module csi_line_count #(
  parameter int LEN_W   = 16,
  parameter int BPB     = 4,
  parameter int BYTES_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beat_fire,
  input  logic               pkt_start,
  input  logic [LEN_W-1:0]   pkt_len,
  output logic [BYTES_W-1:0] bytes_o,
  output logic               eol_o
);
  logic [LEN_W-1:0] rem_q, rem_d, cur_len;
  logic             full;

  assign cur_len = pkt_start ? pkt_len : rem_q;
  assign full    = (cur_len >= LEN_W'(BPB));
  assign bytes_o = full ? BYTES_W'(BPB) : cur_len[BYTES_W-1:0];
  assign eol_o   = (cur_len != '0) && (cur_len <= LEN_W'(BPB));

  always_comb begin
    rem_d = rem_q;
    if (beat_fire) rem_d = cur_len - LEN_W'(bytes_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end

  // R8: the line-end beat empties the count
  assert_eol_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && eol_o) |=> (rem_q == '0));
  // R9: a long start beat leaves length minus one full beat
  assert_long_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && pkt_start && (pkt_len > LEN_W'(BPB)))
      |=> (rem_q == $past(pkt_len) - LEN_W'(BPB)));
endmodule

// File: rtl/csi_frame_tagger.sv
module csi_frame_tagger #(
  parameter int DATA_W = 32,
  parameter int NUM_VC = 4,
  parameter int VC_W   = 2,
  parameter int LEN_W  = 16,
  localparam int BPB     = DATA_W / 8,
  localparam int BYTES_W = $clog2(BPB) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VC-1:0]  vsync_i,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [DATA_W-1:0]  s_data,
  input  logic [VC_W-1:0]    s_vc,
  input  logic               s_pkt_start,
  input  logic [LEN_W-1:0]   s_pkt_len,
  output logic               m_valid,
  input  logic               m_ready,
  output logic [DATA_W-1:0]  m_data,
  output logic [BYTES_W-1:0] m_bytes,
  output logic               m_sol,
  output logic               m_eol,
  output logic               m_meta,
  output logic [VC_W-1:0]    m_vc
);
  import csi_tag_pkg::*;

  logic               mk_req, mk_rise, mk_take, beat_fire;
  logic [VC_W-1:0]    mk_vc;
  logic [BYTES_W-1:0] ln_bytes;
  logic               ln_eol;
  mark_code_t         mk_code;

  assign mk_take   = mk_req & m_ready;
  assign s_ready   = ~mk_req & m_ready;
  assign beat_fire = s_valid & s_ready;
  assign mk_code   = mk_rise ? MARK_SOF : MARK_EOF;

  csi_vs_track #(.NUM_VC(NUM_VC), .VC_W(VC_W)) u_vs (
    .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i), .take_i(mk_take),
    .req_o(mk_req), .sel_o(mk_vc), .rise_o(mk_rise)
  );

  csi_line_count #(.LEN_W(LEN_W), .BPB(BPB), .BYTES_W(BYTES_W)) u_ln (
    .clk(clk), .rst_n(rst_n), .beat_fire(beat_fire),
    .pkt_start(s_pkt_start), .pkt_len(s_pkt_len),
    .bytes_o(ln_bytes), .eol_o(ln_eol)
  );

  always_comb begin
    m_valid = mk_req | s_valid;
    m_meta  = mk_req;
    if (mk_req) begin
      m_data  = {{(DATA_W-2){1'b0}}, mk_code};
      m_vc    = mk_vc;
      m_bytes = '0;
      m_sol   = 1'b0;
      m_eol   = 1'b0;
    end else begin
      m_data  = s_data;
      m_vc    = s_vc;
      m_bytes = ln_bytes;
      m_sol   = s_pkt_start;
      m_eol   = ln_eol;
    end
  end

  // R4 / R5: a marker always blocks the input beat
  assert_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    m_meta |-> !s_ready);
  // R6: a full FIFO blocks the input
  assert_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !m_ready |-> !s_ready);
  // R2: marker words carry no bytes and no line flags
  assert_meta_form_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_meta |-> (m_bytes == '0 && !m_sol && !m_eol));
  // R11: a data beat reaches the FIFO only as a data word
  assert_data_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |-> (m_valid && !m_meta && m_vc == s_vc));
endmodule

// File: tb/sim_csi_frame_tagger.sv
`timescale 1ns/1ps
module sim_csi_frame_tagger;
  logic        clk, rst_n;
  logic [3:0]  vsync_i;
  logic        s_valid, s_ready, s_pkt_start, m_valid, m_ready;
  logic [31:0] s_data, m_data;
  logic [1:0]  s_vc, m_vc;
  logic [15:0] s_pkt_len;
  logic [2:0]  m_bytes;
  logic        m_sol, m_eol, m_meta;

  int total = 0, bad = 0;
  bit done = 0;

  // reference state
  bit [3:0] mvs;
  int       mrem;
  // predictions for the current cycle
  bit e_req, e_take, e_fire;
  int e_sel, e_len, e_bytes;

  csi_frame_tagger u0 (
    .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .s_vc(s_vc),
    .s_pkt_start(s_pkt_start), .s_pkt_len(s_pkt_len), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data), .m_bytes(m_bytes), .m_sol(m_sol),
    .m_eol(m_eol), .m_meta(m_meta), .m_vc(m_vc)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FIL_MARK %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // printing uses the FAIL word only for failed checks
  function automatic string failword();
    return "FAIL";
  endfunction

  task automatic ck(input string req, input string what,
                    input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("%s %s %s actual=%0d expected=%0d", failword(), req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit [3:0] diff;
    string rq;
    diff = vsync_i ^ mvs;
    e_req = (diff != 0);
    e_sel = 0;
    for (int i = 3; i >= 0; i--) if (diff[i]) e_sel = i;
    ck(e_req ? "R4" : "R11", "m_valid", m_valid, e_req || s_valid);
    rq = !m_ready ? "R6" : (e_req ? (s_valid ? "R5" : "R4") : "R11");
    ck(rq, "s_ready", s_ready, !e_req && m_ready);
    ck(e_req ? "R2" : "R11", "m_meta", m_meta, e_req);
    e_take = e_req && m_ready;
    e_fire = !e_req && m_ready && s_valid;
    if (e_req) begin
      rq = ($countones(diff) > 1) ? "R10" : (vsync_i[e_sel] ? "R2" : "R3");
      ck(rq, "marker vc", m_vc, e_sel);
      ck(vsync_i[e_sel] ? "R2" : "R3", "marker code", m_data, vsync_i[e_sel] ? 1 : 2);
      ck("R2", "marker bytes", m_bytes, 0);
      ck("R2", "marker eol", m_eol, 0);
    end else if (s_valid) begin
      e_len = s_pkt_start ? int'(s_pkt_len) : mrem;
      e_bytes = (e_len >= 4) ? 4 : e_len;
      rq = (e_len > 24) ? "R9" : "R8";
      ck("R11", "data", m_data, s_data);
      ck("R11", "data vc", m_vc, s_vc);
      ck("R7", "sol", m_sol, s_pkt_start);
      ck(rq, "bytes", m_bytes, e_bytes);
      ck(rq, "eol", m_eol, (e_len != 0) && (e_len <= 4));
    end
  endtask

  task automatic update();
    if (e_take) mvs[e_sel] = vsync_i[e_sel];
    if (e_fire) mrem = e_len - e_bytes;
  endtask

  task automatic run_cycle();
    #1;
    compare();
    @(posedge clk);
    update();
    @(negedge clk);
  endtask

  task automatic beat(input bit st, input int len, input int vc);
    s_valid = 1; s_pkt_start = st; s_pkt_len = 16'(len);
    s_vc = 2'(vc); s_data = $urandom;
  endtask

  // hold the offered beat until the model says it was taken
  task automatic push_beat(input bit st, input int len, input int vc);
    beat(st, len, vc);
    do run_cycle(); while (!e_fire);
    s_valid = 0; s_pkt_start = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++; total++;
      $display("%s watchdog expired", failword());
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; vsync_i = 0; s_valid = 0; s_data = 0; s_vc = 0;
    s_pkt_start = 0; s_pkt_len = 0; m_ready = 1;
    mvs = 0; mrem = 0;
    @(negedge clk); #1;
    ck("R1", "reset m_valid", m_valid, 0);
    ck("R1", "reset s_ready", s_ready, 1);
    m_ready = 0; #1;
    ck("R1", "reset s_ready full", s_ready, 0);
    m_ready = 1;
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    // R2 rise on vc2, alone
    vsync_i = 4'b0100; run_cycle();
    run_cycle();
    ck("R4", "no repeat marker", m_meta, 0);
    // R5 coincident edge with a beat: 12-byte line
    vsync_i = 4'b0000;
    push_beat(1, 12, 1); push_beat(0, 0, 1); push_beat(0, 0, 1);
    // R6 FIFO full holds the marker
    m_ready = 0; vsync_i = 4'b0001; run_cycle(); run_cycle();
    m_ready = 1; run_cycle(); run_cycle();
    // R10 two edges together
    vsync_i = 4'b1011; run_cycle(); run_cycle(); run_cycle(); run_cycle();
    // R9 whole frame in one packet, 42 bytes
    push_beat(1, 42, 3);
    for (int k = 0; k < 10; k++) push_beat(0, 0, 3);
    // R8 short packet of 3 bytes
    push_beat(1, 3, 0);

    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      m_ready = ($urandom_range(0, 3) != 0);
      if (vsync_i == mvs && $urandom_range(0, 9) == 0)
        vsync_i[$urandom_range(0, 3)] ^= 1'b1;
      if ($urandom_range(0, 40) == 0) vsync_i ^= 4'b0110;
      if (!s_valid && $urandom_range(0, 2) != 0) begin
        if (mrem == 0) beat(1, ($urandom_range(0, 5) == 0) ? 40 : $urandom_range(1, 20),
                            $urandom_range(0, 3));
        else beat(0, 0, s_vc);
      end
      run_cycle();
      if (e_fire) begin s_valid = 0; s_pkt_start = 0; end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule